// File: doc/BRIEF.md
# Banked Shared Memory with Per-Bank Write Ownership

This block holds a memory shared by two processing subsystems, a master side and a control side, each presenting a CPU port and a DMA port. The storage is cut into eight equal banks. A one-bit owner flag per bank says which side may modify it. Only the master side can rewrite these flags. The owning side has full read, write and instruction-fetch access. The other side may still read data from the bank, but its writes and fetches are refused.

Every request is decoded to a bank by the top bits of its word address. It is then checked against that bank's owner. A permitted request is handed to the bank. A refused request finishes at once: memory is left as it was, the port sees an error response, and a violation report names the bank and the port. Each bank serves one access per cycle. When several permitted requests hit the same bank together, the owner side wins. Within a side, the CPU wins over the DMA. A request that loses the bank keeps its ready low and is served in a later cycle.

A bulk hand-over works like this: the sender takes a bank, fills it, and then raises a flag in a separate inter-core flag block. The default parameters give a small behavioural model. Setting `BANK_WORD_BITS` to 11 with 32-bit words gives 8 KB banks and 64 KB in total.

Top module: `sram_share_top`

## Requirements
- R1: After reset, every owner flag is 0 (all banks belong to the master side), and no response or violation is signalled.
- R2: An ownership write with `ownWrSide`=0 loads `ownWrData` into the flags, and `ownMap` shows the new value from the next cycle. Bit b=1 hands bank b to the control side.
- R3: An ownership write with `ownWrSide`=1 (control side) is ignored, and `ownMap` keeps its value.
- R4: The bank is word-address bits [10:8] and the word offset is bits [7:0] at default parameters. Equal offsets in different banks hold separate data.
- R5: A port's request is accepted in the cycle its `reqReady` is high. `rspValid` follows one cycle later. For an accepted read (type 2'b00) or fetch (2'b10), `rspData` then holds the word, and a read after a write returns the written value.
- R6: A data read from the side that does not own the bank is allowed and returns the bank contents without error.
- R7: A write (type 2'b01, or 2'b11, which is handled as a write) from the non-owning side is refused. `reqReady` is high in the same cycle, `rspErr` is high with `rspValid` one cycle later, and the memory word is unchanged.
- R8: A fetch from the non-owning side is refused like a write. A fetch from the owning side returns the word.
- R9: One cycle after any refusal, `violValid` is high, with `violBank` giving the bank and `violPort` giving the port. If several ports are refused together, the lowest port index is reported.
- R10: Permitted requests to one bank in the same cycle are served one per cycle. The order is: owner CPU, owner DMA, other CPU, other DMA. Ports 0/1 are master CPU/DMA and ports 2/3 are control CPU/DMA.
- R11: Requests presented in the same cycle as an ownership write are checked against the old flags. The new flags apply from the next cycle.
- R12: Requests to different banks are all served in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ownWrEn | input | 1 | Ownership flag write strobe |
| ownWrSide | input | 1 | Side issuing the flag write (0 master, 1 control) |
| ownWrData | input | 8 | New owner flags, one per bank |
| ownMap | output | 8 | Current owner flags |
| reqValid | input | 4 | Request valid per port |
| reqType | input | 8 | 2-bit access type per port |
| reqAddr | input | 4*ADDR_W | Word address per port |
| reqWdata | input | 4*DATA_W | Write data per port |
| reqReady | output | 4 | Request accepted or refused this cycle |
| rspValid | output | 4 | Response present per port |
| rspErr | output | 4 | Response is a refusal |
| rspData | output | 4*DATA_W | Read data per port, zero unless a read or fetch succeeded |
| violValid | output | 1 | A refusal happened in the previous cycle |
| violBank | output | 3 | Bank of the reported refusal |
| violPort | output | 2 | Port of the reported refusal |

## Verification
Some properties are checked by assertions on every cycle. The reset state of the flags, the load and the ignored side of flag writes, and the one-cycle tie between acceptance and response are among them. So are the rule that a refused request finishes immediately with an error, the rule that at most one permitted request wins a bank per cycle, the rule that the owner's CPU is never stalled, and the rule that a violation report points at an erroring port. Other behaviour is shown only by the bench's scenarios. That includes data integrity across banks, the memory left unchanged after a refused write, the full four-level service order across successive cycles, and the use of the old flags in the cycle a flag write happens.

// File: rtl/sram_share_pkg.sv
package sram_share_pkg;

  localparam int NUM_BANKS  = 8;
  localparam int BANK_SEL_W = $clog2(NUM_BANKS);
  localparam int NUM_PORTS  = 4;
  localparam int PORT_W     = $clog2(NUM_PORTS);

  localparam logic SIDE_MASTER  = 1'b0;
  localparam logic SIDE_CONTROL = 1'b1;

  typedef enum logic [1:0] {
    ACC_READ   = 2'b00,
    ACC_WRITE  = 2'b01,
    ACC_FETCH  = 2'b10,
    ACC_WRITE2 = 2'b11
  } accType_e;

  // strobes from control to datapath
  typedef struct packed {
    logic [NUM_BANKS-1:0]             bankEn;
    logic [NUM_BANKS-1:0]             bankWe;
    logic [NUM_BANKS-1:0][PORT_W-1:0] bankSel;
    logic [NUM_PORTS-1:0]             portAcc;
    logic [NUM_PORTS-1:0]             portDeny;
  } strobes_t;

endpackage

// File: rtl/sram_share_ctrl.sv
module sram_share_ctrl
  import sram_share_pkg::*;
(
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            ownWrEn,
  input  logic                            ownWrSide,
  input  logic [NUM_BANKS-1:0]            ownWrData,
  input  logic [NUM_PORTS-1:0]            reqValid,
  input  logic [NUM_PORTS*2-1:0]          reqType,
  input  logic [NUM_PORTS*BANK_SEL_W-1:0] reqBank,
  output logic [NUM_BANKS-1:0]            ownMap,
  output logic [NUM_PORTS-1:0]            reqReady,
  output strobes_t                        strb
);

  logic [NUM_BANKS-1:0]  ownQ;
  logic [BANK_SEL_W-1:0] bankOf [NUM_PORTS];
  logic [NUM_PORTS-1:0]  isWr;
  logic [NUM_PORTS-1:0]  denyV;
  logic [NUM_PORTS-1:0]  want;
  logic [PORT_W-1:0]     cand;

  // owner flags: only the master side may load them
  always_ff @(posedge clk) begin
    if (rst) begin
      ownQ <= '0;
    end else if (ownWrEn && ownWrSide == SIDE_MASTER) begin
      ownQ <= ownWrData;
    end
  end

  assign ownMap = ownQ;

  // per-port permission check
  for (genvar gp = 0; gp < NUM_PORTS; gp++) begin : g_port
    localparam logic PortSide = (gp >= NUM_PORTS/2) ? SIDE_CONTROL : SIDE_MASTER;
    accType_e t;
    assign t          = accType_e'(reqType[gp*2 +: 2]);
    assign bankOf[gp] = reqBank[gp*BANK_SEL_W +: BANK_SEL_W];
    assign isWr[gp]   = (t == ACC_WRITE) || (t == ACC_WRITE2);
    assign denyV[gp]  = reqValid[gp] && (t != ACC_READ) && (ownQ[bankOf[gp]] != PortSide);
    assign want[gp]   = reqValid[gp] && !denyV[gp];
  end

  // fixed-priority bank arbitration: owner CPU, owner DMA, other CPU, other DMA
  always_comb begin
    strb = '0;
    cand = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      for (int k = 0; k < NUM_PORTS; k++) begin
        cand = PORT_W'(k) ^ {ownQ[b], {(PORT_W-1){1'b0}}};
        if (!strb.bankEn[b] && want[cand] && bankOf[cand] == BANK_SEL_W'(b)) begin
          strb.bankEn[b]  = 1'b1;
          strb.bankWe[b]  = isWr[cand];
          strb.bankSel[b] = cand;
        end
      end
    end
    strb.portDeny = denyV;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (strb.bankEn[b]) strb.portAcc[strb.bankSel[b]] = 1'b1;
    end
  end

  assign reqReady = strb.portAcc | strb.portDeny;

endmodule

// File: rtl/sram_share_dp.sv
module sram_share_dp
  import sram_share_pkg::*;
#(
  parameter int DATA_W         = 32,
  parameter int BANK_WORD_BITS = 8
) (
  input  logic                                clk,
  input  logic                                rst,
  input  strobes_t                            strb,
  input  logic [NUM_PORTS*BANK_SEL_W-1:0]     reqBank,
  input  logic [NUM_PORTS*BANK_WORD_BITS-1:0] reqOff,
  input  logic [NUM_PORTS*DATA_W-1:0]         reqWdata,
  output logic [NUM_PORTS-1:0]                rspValid,
  output logic [NUM_PORTS-1:0]                rspErr,
  output logic [NUM_PORTS*DATA_W-1:0]         rspData,
  output logic                                violValid,
  output logic [BANK_SEL_W-1:0]               violBank,
  output logic [PORT_W-1:0]                   violPort
);

  localparam int BankWords = 1 << BANK_WORD_BITS;

  logic [BANK_SEL_W-1:0]     bankArr [NUM_PORTS];
  logic [BANK_WORD_BITS-1:0] offArr  [NUM_PORTS];
  logic [DATA_W-1:0]         wdArr   [NUM_PORTS];
  logic [DATA_W-1:0]         bankRdAll [NUM_BANKS];

  logic [NUM_PORTS-1:0]  rspValidQ, rspErrQ, rspRdQ;
  logic [BANK_SEL_W-1:0] rspBankQ [NUM_PORTS];
  logic                  violNext;
  logic [BANK_SEL_W-1:0] violBankNext;
  logic [PORT_W-1:0]     violPortNext;
  logic                  violValidQ;
  logic [BANK_SEL_W-1:0] violBankQ;
  logic [PORT_W-1:0]     violPortQ;

  for (genvar gp = 0; gp < NUM_PORTS; gp++) begin : g_unpack
    assign bankArr[gp] = reqBank[gp*BANK_SEL_W +: BANK_SEL_W];
    assign offArr[gp]  = reqOff[gp*BANK_WORD_BITS +: BANK_WORD_BITS];
    assign wdArr[gp]   = reqWdata[gp*DATA_W +: DATA_W];
  end

  // one behavioural array per bank
  for (genvar gb = 0; gb < NUM_BANKS; gb++) begin : g_bank
    logic [DATA_W-1:0]         mem [BankWords];
    logic [DATA_W-1:0]         rdQ;
    logic [BANK_WORD_BITS-1:0] selOff;
    logic [DATA_W-1:0]         selWd;

    assign selOff = offArr[strb.bankSel[gb]];
    assign selWd  = wdArr[strb.bankSel[gb]];

    always_ff @(posedge clk) begin
      if (strb.bankEn[gb]) begin
        if (strb.bankWe[gb]) mem[selOff] <= selWd;
        else                 rdQ <= mem[selOff];
      end
    end

    assign bankRdAll[gb] = rdQ;
  end

  // response flags
  always_ff @(posedge clk) begin
    if (rst) begin
      rspValidQ <= '0;
      rspErrQ   <= '0;
      rspRdQ    <= '0;
    end else begin
      rspValidQ <= strb.portAcc | strb.portDeny;
      rspErrQ   <= strb.portDeny;
      for (int p = 0; p < NUM_PORTS; p++) begin
        rspRdQ[p] <= strb.portAcc[p] && !strb.bankWe[bankArr[p]];
      end
    end
  end

  always_ff @(posedge clk) begin
    for (int p = 0; p < NUM_PORTS; p++) rspBankQ[p] <= bankArr[p];
  end

  for (genvar gp = 0; gp < NUM_PORTS; gp++) begin : g_rsp
    assign rspData[gp*DATA_W +: DATA_W] = rspRdQ[gp] ? bankRdAll[rspBankQ[gp]] : '0;
  end

  // violation report: lowest refused port wins
  always_comb begin
    violNext     = 1'b0;
    violBankNext = '0;
    violPortNext = '0;
    for (int p = NUM_PORTS-1; p >= 0; p--) begin
      if (strb.portDeny[p]) begin
        violNext     = 1'b1;
        violBankNext = bankArr[p];
        violPortNext = PORT_W'(p);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      violValidQ <= 1'b0;
      violBankQ  <= '0;
      violPortQ  <= '0;
    end else begin
      violValidQ <= violNext;
      violBankQ  <= violBankNext;
      violPortQ  <= violPortNext;
    end
  end

  assign rspValid  = rspValidQ;
  assign rspErr    = rspErrQ;
  assign violValid = violValidQ;
  assign violBank  = violBankQ;
  assign violPort  = violPortQ;

endmodule

// File: rtl/sram_share_top.sv
module sram_share_top
  import sram_share_pkg::*;
#(
  parameter int DATA_W         = 32,
  parameter int BANK_WORD_BITS = 8,
  localparam int ADDR_W        = BANK_SEL_W + BANK_WORD_BITS
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        ownWrEn,
  input  logic                        ownWrSide,
  input  logic [NUM_BANKS-1:0]        ownWrData,
  output logic [NUM_BANKS-1:0]        ownMap,
  input  logic [NUM_PORTS-1:0]        reqValid,
  input  logic [NUM_PORTS*2-1:0]      reqType,
  input  logic [NUM_PORTS*ADDR_W-1:0] reqAddr,
  input  logic [NUM_PORTS*DATA_W-1:0] reqWdata,
  output logic [NUM_PORTS-1:0]        reqReady,
  output logic [NUM_PORTS-1:0]        rspValid,
  output logic [NUM_PORTS-1:0]        rspErr,
  output logic [NUM_PORTS*DATA_W-1:0] rspData,
  output logic                        violValid,
  output logic [BANK_SEL_W-1:0]       violBank,
  output logic [PORT_W-1:0]           violPort
);

  logic [NUM_PORTS*BANK_SEL_W-1:0]     reqBank;
  logic [NUM_PORTS*BANK_WORD_BITS-1:0] reqOff;
  strobes_t                            strb;

  for (genvar gp = 0; gp < NUM_PORTS; gp++) begin : g_split
    assign reqBank[gp*BANK_SEL_W +: BANK_SEL_W] =
      reqAddr[gp*ADDR_W + BANK_WORD_BITS +: BANK_SEL_W];
    assign reqOff[gp*BANK_WORD_BITS +: BANK_WORD_BITS] =
      reqAddr[gp*ADDR_W +: BANK_WORD_BITS];
  end

  sram_share_ctrl u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .ownWrEn   (ownWrEn),
    .ownWrSide (ownWrSide),
    .ownWrData (ownWrData),
    .reqValid  (reqValid),
    .reqType   (reqType),
    .reqBank   (reqBank),
    .ownMap    (ownMap),
    .reqReady  (reqReady),
    .strb      (strb)
  );

  sram_share_dp #(
    .DATA_W         (DATA_W),
    .BANK_WORD_BITS (BANK_WORD_BITS)
  ) u_dp (
    .clk       (clk),
    .rst       (rst),
    .strb      (strb),
    .reqBank   (reqBank),
    .reqOff    (reqOff),
    .reqWdata  (reqWdata),
    .rspValid  (rspValid),
    .rspErr    (rspErr),
    .rspData   (rspData),
    .violValid (violValid),
    .violBank  (violBank),
    .violPort  (violPort)
  );

endmodule

// File: rtl/sram_share_chk.sv
module sram_share_chk
  import sram_share_pkg::*;
(
  input logic                            clk,
  input logic                            rst,
  input logic                            ownWrEn,
  input logic                            ownWrSide,
  input logic [NUM_BANKS-1:0]            ownWrData,
  input logic [NUM_BANKS-1:0]            ownMap,
  input logic [NUM_PORTS-1:0]            reqValid,
  input logic [NUM_PORTS*2-1:0]          reqType,
  input logic [NUM_PORTS*BANK_SEL_W-1:0] reqBank,
  input logic [NUM_PORTS-1:0]            reqReady,
  input logic [NUM_PORTS-1:0]            rspValid,
  input logic [NUM_PORTS-1:0]            rspErr,
  input logic                            violValid,
  input logic [PORT_W-1:0]               violPort
);

  logic [BANK_SEL_W-1:0] bankOf [NUM_PORTS];
  logic [NUM_PORTS-1:0]  legal;
  logic [NUM_PORTS-1:0]  refused;
  logic [NUM_PORTS-1:0]  readOp;
  logic [NUM_BANKS-1:0][NUM_PORTS-1:0] hit;

  for (genvar gp = 0; gp < NUM_PORTS; gp++) begin : g_p
    localparam logic PortSide = (gp >= NUM_PORTS/2) ? SIDE_CONTROL : SIDE_MASTER;
    assign bankOf[gp]  = reqBank[gp*BANK_SEL_W +: BANK_SEL_W];
    assign readOp[gp]  = (reqType[gp*2 +: 2] == 2'b00);
    assign refused[gp] = reqValid[gp] && !readOp[gp] && (ownMap[bankOf[gp]] != PortSide);
    assign legal[gp]   = reqValid[gp] && !refused[gp];

    AST_RSP_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (rst)
      (reqValid[gp] && reqReady[gp]) |=> rspValid[gp]);                   // R5
    AST_NO_RSP_WITHOUT_ACCEPT: assert property (@(posedge clk) disable iff (rst)
      !(reqValid[gp] && reqReady[gp]) |=> !rspValid[gp]);                 // R5
    AST_REFUSE_AT_ONCE: assert property (@(posedge clk) disable iff (rst)
      refused[gp] |-> reqReady[gp]);                                      // R7
    AST_REFUSE_ERR: assert property (@(posedge clk) disable iff (rst)
      refused[gp] |=> (rspValid[gp] && rspErr[gp]));                      // R8
    AST_FOREIGN_READ_OK: assert property (@(posedge clk) disable iff (rst)
      (reqValid[gp] && reqReady[gp] && readOp[gp]) |=> !rspErr[gp]);      // R6
  end

  for (genvar gb = 0; gb < NUM_BANKS; gb++) begin : g_b
    logic [PORT_W-1:0] ownerCpu;
    assign ownerCpu = {ownMap[gb], {(PORT_W-1){1'b0}}};
    for (genvar gp = 0; gp < NUM_PORTS; gp++) begin : g_h
      assign hit[gb][gp] = legal[gp] && reqReady[gp] && (bankOf[gp] == BANK_SEL_W'(gb));
    end

    AST_ONE_WINNER: assert property (@(posedge clk) disable iff (rst)
      $countones(hit[gb]) <= 1);                                          // R10
    AST_OWNER_CPU_FIRST: assert property (@(posedge clk) disable iff (rst)
      (legal[ownerCpu] && bankOf[ownerCpu] == BANK_SEL_W'(gb)) |-> reqReady[ownerCpu]); // R10
  end

  AST_RESET_STATE: assert property (@(posedge clk)
    rst |=> (ownMap == '0 && rspValid == '0 && !violValid));              // R1
  AST_MAP_LOAD: assert property (@(posedge clk) disable iff (rst)
    (ownWrEn && !ownWrSide) |=> (ownMap == $past(ownWrData)));            // R2
  AST_FOREIGN_MAP_WRITE: assert property (@(posedge clk) disable iff (rst)
    (ownWrEn && ownWrSide) |=> $stable(ownMap));                          // R3
  AST_VIOL_POINTS_AT_ERR: assert property (@(posedge clk) disable iff (rst)
    violValid |-> (rspValid[violPort] && rspErr[violPort]));              // R9

endmodule

bind sram_share_top sram_share_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .ownWrEn   (ownWrEn),
  .ownWrSide (ownWrSide),
  .ownWrData (ownWrData),
  .ownMap    (ownMap),
  .reqValid  (reqValid),
  .reqType   (reqType),
  .reqBank   (reqBank),
  .reqReady  (reqReady),
  .rspValid  (rspValid),
  .rspErr    (rspErr),
  .violValid (violValid),
  .violPort  (violPort)
);

// File: tb/sim_sram_share_top.sv
module sim_sram_share_top;

  localparam int DW = 32;
  localparam int AW = 11;
  localparam logic [1:0] T_RD = 2'b00, T_WR = 2'b01, T_FE = 2'b10;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          ownWrEn = 1'b0;
  logic          ownWrSide = 1'b0;
  logic [7:0]    ownWrData = '0;
  logic [7:0]    ownMap;
  logic [3:0]    reqValid = '0;
  logic [7:0]    reqType = '0;
  logic [4*AW-1:0] reqAddr = '0;
  logic [4*DW-1:0] reqWdata = '0;
  logic [3:0]    reqReady, rspValid, rspErr;
  logic [4*DW-1:0] rspData;
  logic          violValid;
  logic [2:0]    violBank;
  logic [1:0]    violPort;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  typedef struct {
    bit          err;
    bit          chk;
    logic [31:0] data;
    string       req;
  } expItem_t;

  expItem_t expQ [4][$];

  always #2 clk = ~clk;  // 250 MHz

  sram_share_top u0 (
    .clk(clk), .rst(rst), .ownWrEn(ownWrEn), .ownWrSide(ownWrSide),
    .ownWrData(ownWrData), .ownMap(ownMap), .reqValid(reqValid),
    .reqType(reqType), .reqAddr(reqAddr), .reqWdata(reqWdata),
    .reqReady(reqReady), .rspValid(rspValid), .rspErr(rspErr),
    .rspData(rspData), .violValid(violValid), .violBank(violBank),
    .violPort(violPort)
  );

  task automatic check(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [AW-1:0] addr(int b, int off);
    return AW'((b << 8) | off);
  endfunction

  task automatic setReq(int p, logic [1:0] t, logic [AW-1:0] a, logic [31:0] wd);
    reqValid[p] = 1'b1;
    reqType[p*2 +: 2] = t;
    reqAddr[p*AW +: AW] = a;
    reqWdata[p*DW +: DW] = wd;
  endtask

  task automatic clrReq(int p);
    reqValid[p] = 1'b0;
  endtask

  task automatic pushExp(int p, bit err, bit chk, logic [31:0] d, string req);
    expItem_t it;
    it.err = err; it.chk = chk; it.data = d; it.req = req;
    expQ[p].push_back(it);
  endtask

  // driver: one request on one port, waits for ready, queues the expectation
  task automatic doAccess(int p, logic [1:0] t, logic [AW-1:0] a, logic [31:0] wd,
                          bit err, bit chk, logic [31:0] d, string req);
    @(negedge clk);
    setReq(p, t, a, wd);
    #1;
    while (!reqReady[p]) begin
      @(negedge clk);
      #1;
    end
    pushExp(p, err, chk, d, req);
    @(posedge clk);
    #1;
    clrReq(p);
  endtask

  // monitor: compares every response with the queued expectation
  always @(negedge clk) begin
    expItem_t it;
    if (!rst) begin
      for (int p = 0; p < 4; p++) begin
        if (rspValid[p]) begin
          if (expQ[p].size() == 0) begin
            check(1'b0, "R5", $sformatf("unexpected response port %0d", p), 32'(rspValid[p]), 32'd0);
          end else begin
            it = expQ[p].pop_front();
            check(rspErr[p] == it.err, it.req, $sformatf("rspErr port %0d", p),
                  32'(rspErr[p]), 32'(it.err));
            if (it.chk)
              check(rspData[p*DW +: DW] == it.data, it.req, $sformatf("rspData port %0d", p),
                    rspData[p*DW +: DW], it.data);
          end
        end
      end
    end
  end

  task automatic checkViol(int b, int p, string req);
    check(violValid == 1'b1, req, "violValid", 32'(violValid), 32'd1);
    check(violBank == 3'(b), req, "violBank", 32'(violBank), 32'(b));
    check(violPort == 2'(p), req, "violPort", 32'(violPort), 32'(p));
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
    finish();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1;
    // R1 reset state
    check(ownMap == 8'h00, "R1", "ownMap", 32'(ownMap), 32'h0);
    check(rspValid == 4'h0, "R1", "rspValid", 32'(rspValid), 32'h0);
    check(violValid == 1'b0, "R1", "violValid", 32'(violValid), 32'h0);

    // R4/R5: same offset in two banks, plus top offset of bank 1
    doAccess(0, T_WR, addr(0, 5), 32'hA000_000A, 0, 0, '0, "R5");
    doAccess(0, T_WR, addr(7, 5), 32'hB000_000B, 0, 0, '0, "R4");
    doAccess(1, T_WR, addr(1, 255), 32'h1111_00FF, 0, 0, '0, "R4");
    doAccess(0, T_RD, addr(0, 5), '0, 0, 1, 32'hA000_000A, "R4");
    doAccess(0, T_RD, addr(7, 5), '0, 0, 1, 32'hB000_000B, "R4");
    doAccess(1, T_RD, addr(1, 255), '0, 0, 1, 32'h1111_00FF, "R5");

    // R6 foreign data read
    doAccess(2, T_RD, addr(0, 5), '0, 0, 1, 32'hA000_000A, "R6");

    // R7 foreign write refused at once, memory unchanged
    @(negedge clk);
    setReq(3, T_WR, addr(0, 5), 32'hC000_000C);
    #1;
    check(reqReady[3] == 1'b1, "R7", "immediate ready on refusal", 32'(reqReady[3]), 32'd1);
    pushExp(3, 1, 0, '0, "R7");
    @(posedge clk);
    #1;
    clrReq(3);
    checkViol(0, 3, "R9");
    doAccess(0, T_RD, addr(0, 5), '0, 0, 1, 32'hA000_000A, "R7");

    // R8 fetch rules
    doAccess(2, T_FE, addr(7, 5), '0, 1, 0, '0, "R8");
    checkViol(7, 2, "R9");
    doAccess(1, T_FE, addr(7, 5), '0, 0, 1, 32'hB000_000B, "R8");

    // R2 master loads flags; R3 control-side write ignored
    @(negedge clk);
    ownWrEn = 1'b1; ownWrSide = 1'b0; ownWrData = 8'h84;
    @(negedge clk);
    ownWrEn = 1'b0;
    check(ownMap == 8'h84, "R2", "ownMap after master write", 32'(ownMap), 32'h84);
    ownWrEn = 1'b1; ownWrSide = 1'b1; ownWrData = 8'hFF;
    @(negedge clk);
    ownWrEn = 1'b0; ownWrSide = 1'b0;
    @(negedge clk);
    check(ownMap == 8'h84, "R3", "ownMap after control write", 32'(ownMap), 32'h84);

    // new owner of bank 7 writes; old owner now refused
    doAccess(2, T_WR, addr(7, 5), 32'hD000_000D, 0, 0, '0, "R2");
    doAccess(0, T_WR, addr(7, 5), 32'hBAD0_0BAD, 1, 0, '0, "R7");
    doAccess(0, T_RD, addr(7, 5), '0, 0, 1, 32'hD000_000D, "R6");

    // R9 two refusals together: lowest port reported
    @(negedge clk);
    setReq(2, T_WR, addr(0, 1), '0);
    setReq(3, T_WR, addr(0, 1), '0);
    #1;
    check(reqReady[3:2] == 2'b11, "R9", "both refusals ready", 32'(reqReady[3:2]), 32'h3);
    pushExp(2, 1, 0, '0, "R9");
    pushExp(3, 1, 0, '0, "R9");
    @(posedge clk);
    #1;
    clrReq(2); clrReq(3);
    checkViol(0, 2, "R9");

    // R10 control owns bank 7: control CPU before master CPU
    @(negedge clk);
    setReq(0, T_RD, addr(7, 9), '0);
    setReq(2, T_WR, addr(7, 9), 32'hE000_000E);
    #1;
    check(reqReady[2] == 1'b1, "R10", "owner ready", 32'(reqReady[2]), 32'd1);
    check(reqReady[0] == 1'b0, "R10", "non-owner stalled", 32'(reqReady[0]), 32'd0);
    pushExp(2, 0, 0, '0, "R10");
    @(posedge clk);
    #1;
    clrReq(2);
    @(negedge clk);
    #1;
    check(reqReady[0] == 1'b1, "R10", "non-owner served next", 32'(reqReady[0]), 32'd1);
    pushExp(0, 0, 1, 32'hE000_000E, "R10");
    @(posedge clk);
    #1;
    clrReq(0);

    // R10 master owns bank 0: CPU0, then DMA1, then CPU2
    @(negedge clk);
    setReq(0, T_RD, addr(0, 5), '0);
    setReq(1, T_RD, addr(0, 5), '0);
    setReq(2, T_RD, addr(0, 5), '0);
    #1;
    check(reqReady[2:0] == 3'b001, "R10", "cycle 1 winner", 32'(reqReady[2:0]), 32'h1);
    pushExp(0, 0, 1, 32'hA000_000A, "R10");
    @(posedge clk);
    #1;
    clrReq(0);
    @(negedge clk);
    #1;
    check(reqReady[2:1] == 2'b01, "R10", "cycle 2 winner", 32'(reqReady[2:1]), 32'h1);
    pushExp(1, 0, 1, 32'hA000_000A, "R10");
    @(posedge clk);
    #1;
    clrReq(1);
    @(negedge clk);
    #1;
    check(reqReady[2] == 1'b1, "R10", "cycle 3 winner", 32'(reqReady[2]), 32'd1);
    pushExp(2, 0, 1, 32'hA000_000A, "R10");
    @(posedge clk);
    #1;
    clrReq(2);

    // R12 different banks in parallel
    @(negedge clk);
    setReq(0, T_WR, addr(1, 1), 32'hF000_000F);
    setReq(2, T_WR, addr(2, 1), 32'h6000_0006);
    #1;
    check(reqReady == 4'b0101, "R12", "parallel writes ready", 32'(reqReady), 32'h5);
    pushExp(0, 0, 0, '0, "R12");
    pushExp(2, 0, 0, '0, "R12");
    @(posedge clk);
    #1;
    clrReq(0); clrReq(2);
    @(negedge clk);
    setReq(1, T_RD, addr(1, 1), '0);
    setReq(3, T_RD, addr(2, 1), '0);
    #1;
    check(reqReady == 4'b1010, "R12", "parallel reads ready", 32'(reqReady), 32'hA);
    pushExp(1, 0, 1, 32'hF000_000F, "R12");
    pushExp(3, 0, 1, 32'h6000_0006, "R12");
    @(posedge clk);
    #1;
    clrReq(1); clrReq(3);

    // R11 flag change applies from the next cycle
    @(negedge clk);
    ownWrEn = 1'b1; ownWrSide = 1'b0; ownWrData = 8'h8C;
    setReq(2, T_WR, addr(3, 0), 32'h7777_0000);
    #1;
    check(reqReady[2] == 1'b1, "R11", "ready in change cycle", 32'(reqReady[2]), 32'd1);
    pushExp(2, 1, 0, '0, "R11");
    @(posedge clk);
    #1;
    ownWrEn = 1'b0;
    clrReq(2);
    check(ownMap == 8'h8C, "R11", "ownMap updated", 32'(ownMap), 32'h8C);
    doAccess(2, T_WR, addr(3, 0), 32'h8888_0000, 0, 0, '0, "R11");
    doAccess(2, T_RD, addr(3, 0), '0, 0, 1, 32'h8888_0000, "R11");

    repeat (3) @(negedge clk);
    for (int p = 0; p < 4; p++)
      check(expQ[p].size() == 0, "R5", $sformatf("pending responses port %0d", p),
            32'(expQ[p].size()), 32'd0);
    finish();
  end

endmodule